// File: doc/BRIEF.md
# Barrel Shifter with Carry and Status Merge

This unit is the shift datapath of a 32-bit integer core. From one operand it produces a logical left, logical right or arithmetic right shift. The shift amount is a value from 0 to 31. It comes either from a 5-bit immediate field or from the low bits of a second register value, and a select input picks the source.

Along with the shifted word, the unit returns a new status word. Four flags are recomputed: zero, sign, overflow and carry. Carry holds the last bit that left the word. Every other status bit is copied through unchanged.

The unit is purely combinational and has no clock, reset or state. Instruction decode and register file access sit outside it. It has no states and no transitions: every output is a function of the current inputs alone.

Top module: `bsh_unit`

## Requirements
- R1: When `use_reg_cnt_i` is 1, the shift amount is `cnt_reg_i[4:0]`, and bits 31:5 of `cnt_reg_i` have no effect. When it is 0, the amount is `cnt_imm_i` zero-extended, and `cnt_reg_i` has no effect.
- R2: `kind_i` 2'b00 selects logical left shift with zeros entering at bit 0. Code 2'b11 behaves exactly like 2'b00.
- R3: `kind_i` 2'b01 selects logical right shift, with zeros entering at bit 31.
- R4: `kind_i` 2'b10 selects arithmetic right shift, with copies of operand bit 31 entering the vacated upper positions.
- R5: For a right shift (2'b01 or 2'b10) by n from 1 to 31, carry (`status_o[3]`) equals operand bit n-1.
- R6: For a left shift by n from 1 to 31, carry equals operand bit 32-n.
- R7: An amount of 0 returns the operand unchanged and clears carry, for every kind.
- R8: Zero (`status_o[0]`) is 1 exactly when the result is all zeros. Sign (`status_o[1]`) equals result bit 31.
- R9: Overflow (`status_o[2]`) is 0 after every shift, whatever `status_i[2]` was.
- R10: `status_o[7:4]` equals `status_i[7:4]`. This includes the saturation flag at bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Word to be shifted |
| cnt_reg_i | input | 32 | Register value whose low five bits may give the amount |
| cnt_imm_i | input | 5 | Immediate shift amount |
| use_reg_cnt_i | input | 1 | 1 takes the amount from the register, 0 from the immediate |
| kind_i | input | 2 | Shift kind: 00/11 left, 01 logical right, 10 arithmetic right |
| status_i | input | 8 | Incoming status word (Z=0, S=1, OV=2, CY=3, others 7:4) |
| result_o | output | 32 | Shifted word |
| status_o | output | 8 | Status word with Z, S, OV and CY recomputed |

## Verification
The result and all four recomputed flags settle in the same cycle as the inputs that produce them. No register lies on any path, so each is due zero clock edges after the stimulus. The bench applies a stimulus half a clock period after a rising edge and samples after a short settle delay, well before the next edge. The bound checker evaluates its immediate checks whenever the combinational outputs change.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    typedef enum logic [1:0] {
        KIND_SHL     = 2'b00,
        KIND_SHR     = 2'b01,
        KIND_SAR     = 2'b10,
        KIND_SHL_ALT = 2'b11
    } shift_kind_e;

    // positions of the recomputed flags inside the status word
    localparam int FLAG_Z  = 0;
    localparam int FLAG_S  = 1;
    localparam int FLAG_OV = 2;
    localparam int FLAG_CY = 3;

endpackage

// File: rtl/bsh_count_sel.sv
module bsh_count_sel #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic [DATA_W-1:0] reg_val,
    input  logic [CNT_W-1:0]  imm_val,
    input  logic              use_reg,
    output logic [CNT_W-1:0]  amount
);
    // upper register bits take no part in the amount
    logic unused_reg_hi;
    assign unused_reg_hi = ^reg_val[DATA_W-1:CNT_W];

    assign amount = use_reg ? reg_val[CNT_W-1:0] : imm_val;
endmodule

// File: rtl/bsh_core.sv
module bsh_core
    import bsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 5
) (
    input  logic [DATA_W-1:0] value,
    input  logic [CNT_W-1:0]  amount,
    input  shift_kind_e       kind,
    output logic [DATA_W-1:0] shifted,
    output logic              carry_out
);
    // one extra guard bit below the word catches the last bit shifted out
    localparam int EXT_W = DATA_W + 1;

    logic go_left;
    logic fill;
    logic [DATA_W-1:0] oriented;
    logic [DATA_W-1:0] straight;
    logic [CNT_W:0][EXT_W-1:0] stage;

    assign go_left = (kind == KIND_SHL) || (kind == KIND_SHL_ALT);
    assign fill    = (kind == KIND_SAR) && value[DATA_W-1];

    // a left shift is a right shift of the bit-reversed word
    for (genvar i = 0; i < DATA_W; i++) begin : g_in_rev
        assign oriented[i] = go_left ? value[DATA_W-1-i] : value[i];
    end

    assign stage[0] = {oriented, 1'b0};

    for (genvar s = 0; s < CNT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amount[s]
            ? {{STEP{fill}}, stage[s][EXT_W-1:STEP]}
            : stage[s];
    end

    assign straight  = stage[CNT_W][EXT_W-1:1];
    assign carry_out = stage[CNT_W][0];

    for (genvar i = 0; i < DATA_W; i++) begin : g_out_rev
        assign shifted[i] = go_left ? straight[DATA_W-1-i] : straight[i];
    end
endmodule

// File: rtl/bsh_flags.sv
module bsh_flags
    import bsh_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int STATUS_W = 8
) (
    input  logic [DATA_W-1:0]   result,
    input  logic                carry,
    input  logic [STATUS_W-1:0] status_in,
    output logic [STATUS_W-1:0] status_out
);
    always_comb begin
        status_out          = status_in;
        status_out[FLAG_Z]  = (result == '0);
        status_out[FLAG_S]  = result[DATA_W-1];
        status_out[FLAG_OV] = 1'b0;
        status_out[FLAG_CY] = carry;
    end
endmodule

// File: rtl/bsh_unit.sv
module bsh_unit
    import bsh_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int STATUS_W = 8,
    parameter int CNT_W    = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]   operand_i,
    input  logic [DATA_W-1:0]   cnt_reg_i,
    input  logic [CNT_W-1:0]    cnt_imm_i,
    input  logic                use_reg_cnt_i,
    input  logic [1:0]          kind_i,
    input  logic [STATUS_W-1:0] status_i,
    output logic [DATA_W-1:0]   result_o,
    output logic [STATUS_W-1:0] status_o
);
    logic [CNT_W-1:0] amount;
    logic             carry;
    shift_kind_e      kind;

    assign kind = shift_kind_e'(kind_i);

    bsh_count_sel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
        .reg_val (cnt_reg_i),
        .imm_val (cnt_imm_i),
        .use_reg (use_reg_cnt_i),
        .amount  (amount)
    );

    bsh_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .value     (operand_i),
        .amount    (amount),
        .kind      (kind),
        .shifted   (result_o),
        .carry_out (carry)
    );

    bsh_flags #(.DATA_W(DATA_W), .STATUS_W(STATUS_W)) u_flags (
        .result     (result_o),
        .carry      (carry),
        .status_in  (status_i),
        .status_out (status_o)
    );
endmodule

// File: rtl/bsh_unit_chk.sv
module bsh_unit_chk
    import bsh_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int STATUS_W = 8,
    parameter int CNT_W    = $clog2(DATA_W)
) (
    input logic [DATA_W-1:0]   operand_i,
    input logic [DATA_W-1:0]   cnt_reg_i,
    input logic [CNT_W-1:0]    cnt_imm_i,
    input logic                use_reg_cnt_i,
    input logic [1:0]          kind_i,
    input logic [STATUS_W-1:0] status_i,
    input logic [DATA_W-1:0]   result_o,
    input logic [STATUS_W-1:0] status_o
);
    int n;
    logic known;

    always_comb begin
        known = !$isunknown({operand_i, cnt_reg_i, cnt_imm_i, use_reg_cnt_i,
                             kind_i, status_i, result_o, status_o});
        n = use_reg_cnt_i ? int'(cnt_reg_i % DATA_W) : int'(cnt_imm_i);
        if (known) begin
            if (kind_i == 2'b00 || kind_i == 2'b11)
                assert_left_result_R2: assert (result_o == (operand_i << n));
            if (kind_i == 2'b01)
                assert_lsr_result_R3: assert (result_o == (operand_i >> n));
            if (kind_i == 2'b10)
                assert_asr_result_R4: assert (result_o == DATA_W'($signed(operand_i) >>> n));
            if ((kind_i == 2'b01 || kind_i == 2'b10) && n != 0)
                assert_right_carry_R5: assert (status_o[FLAG_CY] == operand_i[n-1]);
            if ((kind_i == 2'b00 || kind_i == 2'b11) && n != 0)
                assert_left_carry_R6: assert (status_o[FLAG_CY] == operand_i[DATA_W-n]);
            if (n == 0)
                assert_zero_count_R7: assert (result_o == operand_i && !status_o[FLAG_CY]);
            assert_zero_flag_R8: assert (status_o[FLAG_Z] == (result_o == '0));
            assert_sign_flag_R8: assert (status_o[FLAG_S] == result_o[DATA_W-1]);
            assert_no_overflow_R9: assert (!status_o[FLAG_OV]);
            assert_passthrough_R10: assert (status_o[STATUS_W-1:4] == status_i[STATUS_W-1:4]);
        end
    end
endmodule

bind bsh_unit bsh_unit_chk #(.DATA_W(DATA_W), .STATUS_W(STATUS_W), .CNT_W(CNT_W)) u_chk (
    .operand_i     (operand_i),
    .cnt_reg_i     (cnt_reg_i),
    .cnt_imm_i     (cnt_imm_i),
    .use_reg_cnt_i (use_reg_cnt_i),
    .kind_i        (kind_i),
    .status_i      (status_i),
    .result_o      (result_o),
    .status_o      (status_o)
);

// File: tb/tb_bsh_unit.sv
`timescale 1ns/1ps
module tb_bsh_unit;
    logic        clk = 1'b0;
    logic [31:0] operand_i = '0;
    logic [31:0] cnt_reg_i = '0;
    logic [4:0]  cnt_imm_i = '0;
    logic        use_reg_cnt_i = 1'b0;
    logic [1:0]  kind_i = 2'b00;
    logic [7:0]  status_i = '0;
    logic [31:0] result_o;
    logic [7:0]  status_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bsh_unit dut (
        .operand_i(operand_i), .cnt_reg_i(cnt_reg_i), .cnt_imm_i(cnt_imm_i),
        .use_reg_cnt_i(use_reg_cnt_i), .kind_i(kind_i), .status_i(status_i),
        .result_o(result_o), .status_o(status_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // drive after a rising edge, sample after settling, before the next edge
    task automatic drive(input logic [1:0] k, input logic ur, input logic [31:0] rv,
                         input logic [4:0] iv, input logic [31:0] x, input logic [7:0] st);
        @(posedge clk);
        #5;
        kind_i = k; use_reg_cnt_i = ur; cnt_reg_i = rv; cnt_imm_i = iv;
        operand_i = x; status_i = st;
        #2;
    endtask

    function automatic logic [31:0] model_res(input logic [1:0] k, input int n, input logic [31:0] x);
        case (k)
            2'b01:   return x >> n;
            2'b10:   return 32'($signed(x) >>> n);
            default: return x << n;
        endcase
    endfunction

    function automatic logic [7:0] model_st(input logic [1:0] k, input int n,
                                            input logic [31:0] x, input logic [7:0] st);
        logic [31:0] r;
        logic cy;
        r = model_res(k, n, x);
        if (n == 0) cy = 1'b0;
        else if (k == 2'b01 || k == 2'b10) cy = x[n-1];
        else cy = x[32-n];
        return {st[7:4], cy, 1'b0, r[31], (r == 32'h0)};
    endfunction

    task automatic t_initial;
        drive(2'b00, 1'b0, 32'h0, 5'd0, 32'h0, 8'h00);
        check("R8 initial result", result_o, 32'h0);
        check("R8 initial status", {24'h0, status_o}, 32'h01);
    endtask

    task automatic t_zero_count;
        for (int k = 0; k < 4; k++) begin
            drive(2'(k), 1'b0, 32'h0, 5'd0, 32'hA5A5_0F0F, 8'h08);
            check("R7 zero count result", result_o, 32'hA5A5_0F0F);
            check("R7 zero count carry", {31'h0, status_o[3]}, 32'h0);
        end
    endtask

    task automatic t_left;
        drive(2'b00, 1'b0, 32'h0, 5'd1, 32'h8000_0001, 8'h00);
        check("R2 shl by 1", result_o, 32'h0000_0002);
        check("R6 shl carry bit31", {31'h0, status_o[3]}, 32'h1);
        drive(2'b00, 1'b0, 32'h0, 5'd31, 32'h0000_0003, 8'h00);
        check("R2 shl by 31", result_o, 32'h8000_0000);
        check("R6 shl carry bit1", {31'h0, status_o[3]}, 32'h1);
        check("R8 sign from result", {31'h0, status_o[1]}, 32'h1);
        drive(2'b11, 1'b0, 32'h0, 5'd8, 32'h1234_5678, 8'h00);
        check("R2 kind 11 as left", result_o, 32'h3456_7800);
    endtask

    task automatic t_shr;
        drive(2'b01, 1'b0, 32'h0, 5'd31, 32'h8000_0000, 8'h00);
        check("R3 shr by 31", result_o, 32'h0000_0001);
        drive(2'b01, 1'b0, 32'h0, 5'd4, 32'h0000_00F0, 8'h00);
        check("R3 shr by 4", result_o, 32'h0000_000F);
        check("R5 shr carry bit3", {31'h0, status_o[3]}, 32'h0);
        drive(2'b01, 1'b0, 32'h0, 5'd5, 32'h0000_00F0, 8'h00);
        check("R5 shr carry bit4", {31'h0, status_o[3]}, 32'h1);
    endtask

    task automatic t_sar;
        drive(2'b10, 1'b0, 32'h0, 5'd31, 32'h8000_0000, 8'h00);
        check("R4 sar by 31", result_o, 32'hFFFF_FFFF);
        check("R8 sar sign", {31'h0, status_o[1]}, 32'h1);
        drive(2'b10, 1'b0, 32'h0, 5'd4, 32'hF000_0008, 8'h00);
        check("R4 sar by 4", result_o, 32'hFF00_0000);
        check("R5 sar carry bit3", {31'h0, status_o[3]}, 32'h1);
    endtask

    task automatic t_count_sel;
        drive(2'b00, 1'b1, 32'hFFFF_FFE3, 5'd7, 32'h0000_0001, 8'h00);
        check("R1 reg amount masked", result_o, 32'h0000_0008);
        drive(2'b00, 1'b0, 32'h0000_0001, 5'd31, 32'h0000_0001, 8'h00);
        check("R1 imm amount used", result_o, 32'h8000_0000);
    endtask

    task automatic t_flags;
        drive(2'b01, 1'b0, 32'h0, 5'd1, 32'h0000_0001, 8'h04);
        check("R8 zero result flag", {31'h0, status_o[0]}, 32'h1);
        check("R5 carry on zero result", {31'h0, status_o[3]}, 32'h1);
        check("R9 overflow cleared", {31'h0, status_o[2]}, 32'h0);
        drive(2'b00, 1'b0, 32'h0, 5'd2, 32'h0000_0001, 8'hF7);
        check("R10 upper bits kept", {24'h0, status_o}, 32'hF0);
        drive(2'b10, 1'b0, 32'h0, 5'd0, 32'h0000_0010, 8'hA5);
        check("R10 saturation bit kept", {24'h0, status_o}, 32'hA0);
    endtask

    task automatic t_sweep;
        logic [31:0] ops [4];
        ops[0] = 32'h8000_0001; ops[1] = 32'h7FFF_FFFE;
        ops[2] = 32'hDEAD_BEEF; ops[3] = 32'h0F0F_F0F0;
        for (int o = 0; o < 4; o++)
            for (int k = 0; k < 4; k++)
                for (int n = 0; n < 32; n++)
                    for (int src = 0; src < 2; src++) begin
                        if (src == 1)
                            drive(2'(k), 1'b1, {27'h5A5A5A5, 5'(n)}, 5'(31 - n), ops[o], 8'h5C);
                        else
                            drive(2'(k), 1'b0, 32'hFFFF_FFFF, 5'(n), ops[o], 8'h5C);
                        check("R1 R2 R3 R4 sweep result", result_o, model_res(2'(k), n, ops[o]));
                        check("R5 R6 R7 R8 R9 R10 sweep status", {24'h0, status_o},
                              {24'h0, model_st(2'(k), n, ops[o], 8'h5C)});
                    end
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_initial();
        t_zero_count();
        t_left();
        t_shr();
        t_sar();
        t_count_sel();
        t_flags();
        t_sweep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule